// File: doc/BRIEF.md
# Encoded Audio Clock Divider

This block turns one fixed module clock into the two clocks an audio serial port needs: a master clock for an external converter and a bit clock for the local frame logic. Each clock has its own 4-bit ratio code. The codes do not encode the divide value directly. Instead, each code selects an entry from a fixed, nonlinear set of ratios, so that common audio ratios (such as 176 and 192) can be reached with only four bits.

Every ratio except 1 is even, and the divided output is high for exactly half of its period. Ratio 1 forwards the module clock unchanged. A new code is applied only when the current output period ends, so a code change never produces a truncated pulse. The master clock can be gated off with an enable input, and a code of zero is reported as an error.

For the bit clock, the block also produces one-cycle strobes that mark its rising and falling edges in the module-clock domain. The frame formatter uses these strobes. A typical setup runs a 24.576 MHz module clock with master code 1 (divide by 1) and bit code 5 (divide by 8). This gives a 3.072 MHz bit clock: 32-bit slots, two slots per frame, at 48 kHz.

Top module: `audio_clk_div`

## Requirements
- R1: The code selects the divide ratio as follows. Code 1→1, 2→2, 3→4, 4→6, 5→8, 6→12, 7→16, 8→24, 9→32, 10→48, 11→64, 12→96, 13→128, 14→176, 15→192. This mapping is the same for the master clock and the bit clock.
- R2: For a ratio R of 2 or more, the output is high for R/2 module-clock cycles and then low for R/2 cycles.
- R3: For ratio 1, the output equals the module clock. For the master clock, this also requires the enable to be set. While the bit clock is in ratio-1 mode, both bit-clock strobes are high in every cycle.
- R4: Code 0 is invalid. `code_err_o` is a registered flag: it is high in the cycle after a clock edge at which either code was 0. A divider that loads code 0 holds its output low and produces no strobes until it loads a valid code.
- R5: A code change takes effect only at the end of the output period that is in progress. That period completes with its old high and low lengths, and the next period starts high with the new ratio.
- R6: While the registered master enable is low, `mclk_o` is 0. The enable input is sampled only at the end of a master-clock period.
- R7: For a ratio of 2 or more, `bclk_rise_o` is high for exactly one cycle: the first cycle in which the bit clock is high. `bclk_fall_o` is high for exactly one cycle: the first low cycle after a high phase.
- R8: While reset is held, all outputs are 0. On the first clock edge after reset, each divider loads its code and starts a period in the high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mclk_code_i | input | 4 | Master-clock ratio code |
| bclk_code_i | input | 4 | Bit-clock ratio code |
| mclk_oe_i | input | 1 | Master-clock output enable |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Bit clock |
| bclk_rise_o | output | 1 | Strobe marking the bit-clock rising edge |
| bclk_fall_o | output | 1 | Strobe marking the bit-clock falling edge |
| code_err_o | output | 1 | Invalid-code flag |

## Verification
The assertions check the following on every cycle:
- the error flag follows the codes presented one edge earlier;
- a divider that loads code 0 holds its output low;
- the outputs rise only at a period boundary;
- the enable changes only at a boundary, and a disabled master clock stays low;
- a bit-clock strobe lasts one cycle and agrees with the level it marks.

The bench scenarios cover what a single-cycle property cannot show:
- the exact period and high-phase length for each of several codes, including 176 and 192;
- a code change made mid-period, where the old period must finish intact;
- ratio-1 pass-through, checked in both clock phases;
- recovery from code 0.

// File: rtl/acd_pkg.sv
package acd_pkg;
  localparam int unsigned CODE_W  = 4;
  localparam int unsigned RATIO_W = 8;
  localparam int unsigned NDIV    = 2;
  localparam int unsigned DIV_M   = 0;
  localparam int unsigned DIV_B   = 1;

  typedef logic [CODE_W-1:0]  code_t;
  typedef logic [RATIO_W-1:0] ratio_t;

  // Nonlinear code-to-ratio mapping; 0 means "no ratio".
  function automatic ratio_t acd_ratio(input code_t c);
    ratio_t r;
    case (c)
      code_t'(1):  r = ratio_t'(1);
      code_t'(2):  r = ratio_t'(2);
      code_t'(3):  r = ratio_t'(4);
      code_t'(4):  r = ratio_t'(6);
      code_t'(5):  r = ratio_t'(8);
      code_t'(6):  r = ratio_t'(12);
      code_t'(7):  r = ratio_t'(16);
      code_t'(8):  r = ratio_t'(24);
      code_t'(9):  r = ratio_t'(32);
      code_t'(10): r = ratio_t'(48);
      code_t'(11): r = ratio_t'(64);
      code_t'(12): r = ratio_t'(96);
      code_t'(13): r = ratio_t'(128);
      code_t'(14): r = ratio_t'(176);
      code_t'(15): r = ratio_t'(192);
      default:     r = '0;
    endcase
    return r;
  endfunction

  function automatic logic acd_code_ok(input code_t c);
    return acd_ratio(c) != '0;
  endfunction
endpackage

// File: rtl/acd_ratio_lut.sv
module acd_ratio_lut
  import acd_pkg::*;
(
  input  code_t  code_i,
  output ratio_t ratio_o,
  output logic   ok_o
);
  always_comb begin
    ratio_o = acd_ratio(code_i);
    ok_o    = (ratio_o != '0);
  end
endmodule

// File: rtl/acd_divider.sv
module acd_divider
  import acd_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_i,
  input  code_t code_i,
  output logic  lvl_o,
  output logic  pt_o,
  output logic  bound_o
);
  localparam ratio_t ONE = ratio_t'(1);

  ratio_t lut_ratio;
  logic   lut_ok;

  acd_ratio_lut u_lut (
    .code_i  (code_i),
    .ratio_o (lut_ratio),
    .ok_o    (lut_ok)
  );

  ratio_t ratio_q;
  ratio_t cnt_q;
  logic   run_q;
  logic   lvl_q;
  logic   pt_q;
  ratio_t last_cnt;
  ratio_t fall_cnt;

  assign last_cnt = ratio_q - ONE;
  assign fall_cnt = (ratio_q >> 1) - ONE;

  // A period ends on its last count; a stopped or pass-through divider
  // is at a boundary on every cycle.
  assign bound_o = !run_q || pt_q || (cnt_q == last_cnt);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ratio_q <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      lvl_q   <= 1'b0;
      pt_q    <= 1'b0;
    end else if (bound_o) begin
      cnt_q <= '0;
      if (lut_ok) begin
        ratio_q <= lut_ratio;
        run_q   <= 1'b1;
        pt_q    <= (lut_ratio == ONE);
        lvl_q   <= (lut_ratio != ONE);
      end else begin
        ratio_q <= '0;
        run_q   <= 1'b0;
        pt_q    <= 1'b0;
        lvl_q   <= 1'b0;
      end
    end else begin
      cnt_q <= cnt_q + ONE;
      if (cnt_q == fall_cnt) begin
        lvl_q <= 1'b0;
      end
    end
  end

  assign lvl_o = lvl_q;
  assign pt_o  = pt_q;
endmodule

// File: rtl/acd_edge_strobe.sv
module acd_edge_strobe (
  input  logic clk_i,
  input  logic rst_i,
  input  logic lvl_i,
  input  logic pt_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) prev_q <= 1'b0;
    else       prev_q <= lvl_i;
  end

  // Derived from flops only; in pass-through each cycle holds both edges.
  assign rise_o = pt_i | (lvl_i & ~prev_q);
  assign fall_o = pt_i | (~lvl_i & prev_q);
endmodule

// File: rtl/audio_clk_div.sv
module audio_clk_div
  import acd_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [CODE_W-1:0]   mclk_code_i,
  input  logic [CODE_W-1:0]   bclk_code_i,
  input  logic                mclk_oe_i,
  output logic                mclk_o,
  output logic                bclk_o,
  output logic                bclk_rise_o,
  output logic                bclk_fall_o,
  output logic                code_err_o
);
  code_t           code_arr [NDIV];
  logic [NDIV-1:0] lvl;
  logic [NDIV-1:0] pt;
  logic [NDIV-1:0] bnd;
  logic            oe_q;
  logic            err_q;

  assign code_arr[DIV_M] = mclk_code_i;
  assign code_arr[DIV_B] = bclk_code_i;

  for (genvar i = 0; i < NDIV; i++) begin : g_div
    acd_divider u_div (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .code_i  (code_arr[i]),
      .lvl_o   (lvl[i]),
      .pt_o    (pt[i]),
      .bound_o (bnd[i])
    );
  end

  // Enable changes only between master-clock periods.
  always_ff @(posedge clk_i) begin
    if (rst_i)           oe_q <= 1'b0;
    else if (bnd[DIV_M]) oe_q <= mclk_oe_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) err_q <= 1'b0;
    else       err_q <= !acd_code_ok(mclk_code_i) || !acd_code_ok(bclk_code_i);
  end

  acd_edge_strobe u_stb (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .lvl_i  (lvl[DIV_B]),
    .pt_i   (pt[DIV_B]),
    .rise_o (bclk_rise_o),
    .fall_o (bclk_fall_o)
  );

  assign mclk_o     = oe_q & (pt[DIV_M] ? clk_i : lvl[DIV_M]);
  assign bclk_o     = pt[DIV_B] ? clk_i : lvl[DIV_B];
  assign code_err_o = err_q;
endmodule

// File: rtl/acd_checker.sv
module acd_checker
  import acd_pkg::*;
(
  input logic  clk_i,
  input logic  rst_i,
  input code_t m_code,
  input code_t b_code,
  input logic  m_lvl,
  input logic  b_lvl,
  input logic  b_pt,
  input logic  m_bnd,
  input logic  b_bnd,
  input logic  oe_q,
  input logic  mclk_o,
  input logic  bclk_rise_o,
  input logic  bclk_fall_o,
  input logic  code_err_o
);
  a_r4_err_flag: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> (code_err_o == ($past(m_code) == '0 || $past(b_code) == '0)));

  a_r4_stop_low: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(b_bnd) && $past(b_code) == '0)
      |-> (!b_lvl && !b_pt && !bclk_rise_o && !bclk_fall_o));

  a_r5_brise_at_bound: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(b_lvl) |-> $past(b_bnd));

  a_r5_mrise_at_bound: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(m_lvl) |-> $past(m_bnd));

  a_r6_gated_low: assert property (@(posedge clk_i) disable iff (rst_i)
    !oe_q |-> !mclk_o);

  a_r6_oe_at_bound: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !$past(m_bnd)) |-> $stable(oe_q));

  a_r7_rise_one_wide: assert property (@(posedge clk_i) disable iff (rst_i)
    (bclk_rise_o && !b_pt) |=> (!bclk_rise_o || b_pt));

  a_r7_rise_level: assert property (@(posedge clk_i) disable iff (rst_i)
    (bclk_rise_o && !b_pt) |-> b_lvl);

  a_r7_fall_level: assert property (@(posedge clk_i) disable iff (rst_i)
    (bclk_fall_o && !b_pt) |-> !b_lvl);
endmodule

bind audio_clk_div acd_checker u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .m_code      (mclk_code_i),
  .b_code      (bclk_code_i),
  .m_lvl       (lvl[0]),
  .b_lvl       (lvl[1]),
  .b_pt        (pt[1]),
  .m_bnd       (bnd[0]),
  .b_bnd       (bnd[1]),
  .oe_q        (oe_q),
  .mclk_o      (mclk_o),
  .bclk_rise_o (bclk_rise_o),
  .bclk_fall_o (bclk_fall_o),
  .code_err_o  (code_err_o)
);

// File: tb/audio_clk_div_test.sv
`timescale 1ns/1ps
module audio_clk_div_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] mclk_code = 4'd5;
  logic [3:0] bclk_code = 4'd5;
  logic       mclk_oe = 1'b1;
  logic       mclk_o, bclk_o, bclk_rise_o, bclk_fall_o, code_err_o;

  int  vectors = 0;
  int  fails   = 0;
  bit  done    = 0;

  always #5 clk = ~clk;

  audio_clk_div uut (
    .clk_i       (clk),
    .rst_i       (rst),
    .mclk_code_i (mclk_code),
    .bclk_code_i (bclk_code),
    .mclk_oe_i   (mclk_oe),
    .mclk_o      (mclk_o),
    .bclk_o      (bclk_o),
    .bclk_rise_o (bclk_rise_o),
    .bclk_fall_o (bclk_fall_o),
    .code_err_o  (code_err_o)
  );

  function automatic int exp_ratio(input logic [3:0] c);
    case (c)
      4'd1: return 1;    4'd2: return 2;    4'd3: return 4;
      4'd4: return 6;    4'd5: return 8;    4'd6: return 12;
      4'd7: return 16;   4'd8: return 24;   4'd9: return 32;
      4'd10: return 48;  4'd11: return 64;  4'd12: return 96;
      4'd13: return 128; 4'd14: return 176; 4'd15: return 192;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Waits for the first bit-clock rise strobe; returns 1 when seen.
  task automatic wait_brise(output bit got);
    got = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (bclk_rise_o) begin got = 1; break; end
    end
  endtask

  // Measures one bit-clock period starting at a rise sample.
  task automatic bperiod(output int n, output int hi, output int falls, output int fall_at);
    n = 0; hi = 1; falls = 0; fall_at = -1;
    for (int k = 1; k <= 600; k++) begin
      @(negedge clk);
      if (bclk_rise_o) begin n = k; break; end
      if (bclk_o) hi++;
      if (bclk_fall_o) begin falls++; fall_at = k; end
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(!mclk_o && !bclk_o, "R8 outputs low in reset", int'(mclk_o | bclk_o), 0);
    chk(!bclk_rise_o && !bclk_fall_o && !code_err_o, "R8 strobes/err low in reset",
        int'(bclk_rise_o | bclk_fall_o | code_err_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(bclk_rise_o && bclk_o, "R8 bit clock starts high after reset", int'(bclk_o), 1);
    chk(mclk_o, "R8 master clock starts high after reset", int'(mclk_o), 1);
  endtask

  task automatic t_bclk_ratio(input logic [3:0] code);
    int r, n, hi, falls, fall_at;
    bit got;
    r = exp_ratio(code);
    bclk_code = code;
    wait_brise(got);
    chk(got, "R1 bit clock rise seen", int'(got), 1);
    chk(bclk_o, "R7 rise strobe on first high cycle", int'(bclk_o), 1);
    bperiod(n, hi, falls, fall_at);
    chk(n == r, "R1 bit clock period", n, r);
    chk(hi == r / 2, "R2 bit clock high length", hi, r / 2);
    chk(falls == 1 && fall_at == r / 2, "R7 fall strobe position", fall_at, r / 2);
  endtask

  task automatic t_mclk_ratio(input logic [3:0] code);
    int r, n, hi;
    bit prev, got;
    r = exp_ratio(code);
    mclk_code = code;
    mclk_oe = 1'b1;
    @(negedge clk);
    prev = mclk_o; got = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (mclk_o && !prev) begin got = 1; break; end
      prev = mclk_o;
    end
    chk(got, "R1 master clock rise seen", int'(got), 1);
    n = 0; hi = 1; prev = 1;
    for (int k = 1; k <= 600; k++) begin
      @(negedge clk);
      if (mclk_o && !prev) begin n = k; break; end
      if (mclk_o) hi++;
      prev = mclk_o;
    end
    chk(n == r, "R1 master clock period", n, r);
    chk(hi == r / 2, "R2 master clock high length", hi, r / 2);
  endtask

  task automatic t_change_mid_period;
    int n, hi, falls, fall_at;
    bit got;
    bclk_code = 4'd5;
    wait_brise(got);
    wait_brise(got);
    @(negedge clk);
    bclk_code = 4'd2;
    n = 0; hi = 2;
    for (int k = 2; k <= 600; k++) begin
      @(negedge clk);
      if (bclk_rise_o) begin n = k; break; end
      if (bclk_o) hi++;
    end
    chk(n == 8, "R5 old period completes", n, 8);
    chk(hi == 4, "R5 old high phase intact", hi, 4);
    bperiod(n, hi, falls, fall_at);
    chk(n == 2, "R5 new ratio after boundary", n, 2);
  endtask

  task automatic t_passthrough;
    bclk_code = 4'd1;
    mclk_code = 4'd1;
    mclk_oe = 1'b1;
    repeat (400) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #2;
      chk(bclk_o && mclk_o, "R3 pass-through high phase", int'(bclk_o & mclk_o), 1);
      @(negedge clk); #2;
      chk(!bclk_o && !mclk_o, "R3 pass-through low phase", int'(bclk_o | mclk_o), 0);
      chk(bclk_rise_o && bclk_fall_o, "R3 both strobes in pass-through",
          int'(bclk_rise_o & bclk_fall_o), 1);
    end
  endtask

  task automatic t_enable;
    bit got, prev;
    mclk_code = 4'd1;
    mclk_oe = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #2;
      chk(!mclk_o, "R6 disabled master clock low (high phase)", int'(mclk_o), 0);
    end
    mclk_code = 4'd5;
    repeat (20) @(negedge clk);
    got = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (mclk_o) got = 1;
    end
    chk(!got, "R6 disabled divided master clock low", int'(got), 0);
    mclk_oe = 1'b1;
    got = 0; prev = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (mclk_o && !prev) got = 1;
      prev = mclk_o;
    end
    chk(got, "R6 master clock resumes after enable", int'(got), 1);
  endtask

  task automatic t_invalid;
    bit seen;
    bclk_code = 4'd5;
    mclk_code = 4'd5;
    @(negedge clk);
    @(negedge clk);
    chk(!code_err_o, "R4 no error on valid codes", int'(code_err_o), 0);
    bclk_code = 4'd0;
    @(negedge clk);
    chk(code_err_o, "R4 error after bit code 0", int'(code_err_o), 1);
    repeat (20) @(negedge clk);
    seen = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (bclk_o || bclk_rise_o || bclk_fall_o) seen = 1;
    end
    chk(!seen, "R4 stopped bit clock stays low", int'(seen), 0);
    bclk_code = 4'd5;
    @(negedge clk);
    chk(!code_err_o, "R4 error clears", int'(code_err_o), 0);
    chk(bclk_rise_o && bclk_o, "R4 restart on next cycle", int'(bclk_rise_o), 1);
    mclk_code = 4'd0;
    @(negedge clk);
    chk(code_err_o, "R4 error after master code 0", int'(code_err_o), 1);
    mclk_code = 4'd5;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_bclk_ratio(4'd5);
    t_bclk_ratio(4'd2);
    t_bclk_ratio(4'd3);
    t_bclk_ratio(4'd4);
    t_bclk_ratio(4'd8);
    t_bclk_ratio(4'd14);
    t_bclk_ratio(4'd15);
    t_mclk_ratio(4'd6);
    t_mclk_ratio(4'd13);
    t_change_mid_period();
    t_passthrough();
    t_enable();
    t_invalid();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule